// File: doc/BRIEF.md
# Outbound Window Address Translator

This block maps addresses leaving the processor side of a PCIe root port onto PCIe bus addresses. The outbound region is split into equal windows. Every window has the same size, chosen by a 3-bit size code as a power-of-two number of megabytes. Each window carries its own 64-bit bus offset and an enable flag. A global translation enable gates the whole unit.

Software programs the unit through a simple write port. For a direct 1:1 map, consecutive windows get offsets that rise by one window size each. The requester then presents an address relative to the outbound region base. One clock later the unit returns the translated 64-bit bus address together with a hit flag. On a miss, the returned address is zero.

Top module: `ob_xlate`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_addr are all zero. The global enable, every window enable and the size code are also cleared, so every lookup misses until the unit is programmed.
- R2: The size code is bits [2:0] of the register at offset 0x030, and the window size is 2^code MiB. A write to this register changes lookups presented in later cycles. A lookup presented in the same cycle as the write still uses the old size.
- R3: Window n keeps the low 32 bits of its offset at 0x200+8·n and the high 32 bits at 0x204+8·n. The following writes change no state: writes to offsets that are not word aligned, writes to window numbers at or above NUM_WIN, and writes to unmapped offsets.
- R4: The window used for a lookup is the relative address shifted right by 20+code bits.
- R5: On a hit, rsp_addr has three parts. The upper 32 bits are the window's high word. The low word is the window's low word with every bit below the window size cleared, which includes the enable in bit 0. The address modulo the window size is then added to this base.
- R6: Bit 1 of the command register at 0x004 is the global translation enable. While it is clear, every lookup misses. The other bits of a write to that register are ignored.
- R7: Bit 0 of a window's low word enables that window. A lookup that lands on a disabled window misses.
- R8: A lookup whose window number is NUM_WIN or higher misses. Every miss returns rsp_addr equal to zero.
- R9: rsp_valid is high in exactly the cycle after a cycle with lk_valid high. rsp_hit and rsp_addr hold their values while no lookup is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | AW (32) | Address relative to outbound region base |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Translation hit |
| rsp_addr | output | 64 | Translated bus address, zero on a miss |

## Verification
The bench aims at these corner cases:
- Window edges: the first byte of a window and the last byte of window 31. A divider off by one would land either address in the neighbouring window.
- Addresses one past the last window. A design that wraps the window index would hit instead of missing.
- A window with a nonzero high word, and base words whose enable bit is set. A design that does not clear the enable bit would set bit 0 of the output.
- A size change written in the same cycle as a lookup. A design without the register stage would return the new mapping one lookup too early.
- Stray writes to misaligned, out-of-range and unmapped offsets. Loose address decoding would corrupt the window table or the size code.

// File: rtl/ob_pkg.sv
package ob_pkg;
    localparam int CFG_AW      = 12;
    localparam int MB_SHIFT    = 20;
    localparam int SIZE_W      = 3;
    localparam int XLATE_EN_B  = 1;
    localparam int WIN_EN_B    = 0;
    localparam logic [CFG_AW-1:0] CMD_OFF  = 12'h004;
    localparam logic [CFG_AW-1:0] SIZE_OFF = 12'h030;
    localparam logic [CFG_AW-1:0] WIN_BASE = 12'h200;

    typedef struct packed {
        logic        valid;
        logic        hit;
        logic [63:0] addr;
    } rsp_t;
endpackage

// File: rtl/ob_regfile.sv
module ob_regfile
    import ob_pkg::*;
#(
    parameter int NUM_WIN = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [31:0]                    cfg_wdata,
    output logic                           glb_en,
    output logic [SIZE_W-1:0]              size_idx,
    output logic [NUM_WIN-1:0][31:0]       win_lo,
    output logic [NUM_WIN-1:0][31:0]       win_hi
);
    typedef struct packed {
        logic                     glb_en;
        logic [SIZE_W-1:0]        size_idx;
        logic [NUM_WIN-1:0][31:0] lo;
        logic [NUM_WIN-1:0][31:0] hi;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [CFG_AW-1:0] win_rel;
    logic [CFG_AW-1:0] win_num;
    logic              in_win;

    always_comb begin
        win_rel = cfg_addr - WIN_BASE;
        win_num = win_rel >> 3;
        in_win  = (cfg_addr >= WIN_BASE) && (win_num < CFG_AW'(NUM_WIN))
                  && (cfg_addr[1:0] == 2'b00);
    end

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            if (cfg_addr == CMD_OFF) begin
                regs_d.glb_en = cfg_wdata[XLATE_EN_B];
            end else if (cfg_addr == SIZE_OFF) begin
                regs_d.size_idx = cfg_wdata[SIZE_W-1:0];
            end else if (in_win) begin
                for (int n = 0; n < NUM_WIN; n++) begin
                    if (win_num == CFG_AW'(n)) begin
                        if (win_rel[2]) regs_d.hi[n] = cfg_wdata;
                        else            regs_d.lo[n] = cfg_wdata;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign glb_en   = regs_q.glb_en;
    assign size_idx = regs_q.size_idx;
    assign win_lo   = regs_q.lo;
    assign win_hi   = regs_q.hi;
endmodule

// File: rtl/ob_win_lookup.sv
module ob_win_lookup
    import ob_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NUM_WIN = 32
) (
    input  logic [AW-1:0]                lk_addr,
    input  logic                         glb_en,
    input  logic [SIZE_W-1:0]            size_idx,
    input  logic [NUM_WIN-1:0][31:0]     win_lo,
    input  logic [NUM_WIN-1:0][31:0]     win_hi,
    output logic                         hit,
    output logic [63:0]                  bus_addr
);
    localparam int IDX_W = $clog2(NUM_WIN);

    logic [5:0]       shift;
    logic [AW-1:0]    idx_full;
    logic [IDX_W-1:0] sel;
    logic             in_range;
    logic [63:0]      mask;
    logic [63:0]      base;
    logic [63:0]      addr_ext;
    logic [NUM_WIN-1:0] win_on;

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_en
        assign win_on[n] = win_lo[n][WIN_EN_B];
    end

    always_comb begin
        shift    = 6'(MB_SHIFT) + 6'(size_idx);
        idx_full = lk_addr >> shift;
        in_range = idx_full < AW'(NUM_WIN);
        sel      = idx_full[IDX_W-1:0];
        mask     = (64'd1 << shift) - 64'd1;
        addr_ext = {{(64-AW){1'b0}}, lk_addr};
        base     = {win_hi[sel], win_lo[sel]} & ~mask;
        hit      = glb_en && in_range && win_on[sel];
        bus_addr = hit ? (base + (addr_ext & mask)) : 64'd0;
    end
endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
    import ob_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NUM_WIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              lk_valid,
    input  logic [AW-1:0]     lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [63:0]       rsp_addr
);
    logic                     glb_en;
    logic [SIZE_W-1:0]        size_idx;
    logic [NUM_WIN-1:0][31:0] win_lo;
    logic [NUM_WIN-1:0][31:0] win_hi;
    logic                     lk_hit;
    logic [63:0]              lk_bus;

    rsp_t rsp_d, rsp_q;

    ob_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .glb_en   (glb_en),
        .size_idx (size_idx),
        .win_lo   (win_lo),
        .win_hi   (win_hi)
    );

    ob_win_lookup #(.AW(AW), .NUM_WIN(NUM_WIN)) u_lookup (
        .lk_addr  (lk_addr),
        .glb_en   (glb_en),
        .size_idx (size_idx),
        .win_lo   (win_lo),
        .win_hi   (win_hi),
        .hit      (lk_hit),
        .bus_addr (lk_bus)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = lk_valid;
        if (lk_valid) begin
            rsp_d.hit  = lk_hit;
            rsp_d.addr = lk_bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_addr  = rsp_q.addr;
endmodule

// File: rtl/ob_xlate_chk.sv
module ob_xlate_chk
    import ob_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NUM_WIN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [AW-1:0]     lk_addr,
    input logic              glb_en,
    input logic [SIZE_W-1:0] size_idx,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [63:0]       rsp_addr
);
    logic [63:0] region_end;
    logic        past_region;
    always_comb begin
        region_end  = 64'(NUM_WIN) << (MB_SHIFT + int'(size_idx));
        past_region = {{(64-AW){1'b0}}, lk_addr} >= region_end;
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rsp_valid); // R9
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !rsp_valid); // R9
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> ($stable(rsp_addr) && $stable(rsp_hit))); // R9
    AST_GLOBAL_OFF_MISS: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && !glb_en) |=> !rsp_hit); // R6
    AST_PAST_REGION_MISS: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && past_region) |=> !rsp_hit); // R8
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> (rsp_addr == 64'd0)); // R8
    AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_hit) |-> (rsp_addr[MB_SHIFT-1:0] == $past(lk_addr[MB_SHIFT-1:0]))); // R5
endmodule

bind ob_xlate ob_xlate_chk #(.AW(AW), .NUM_WIN(NUM_WIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .glb_en   (glb_en),
    .size_idx (size_idx),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_addr (rsp_addr)
);

// File: tb/ob_xlate_bench.sv
module ob_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [63:0] rsp_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ob_xlate u_ob_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        h;
        logic [63:0] e;
    } vec_t;

    // 4 MiB windows, window n low word 0x8000_0000 + n*4MiB, window 3 high word 0x12, window 5 off
    localparam vec_t VECS [8] = '{
        '{32'h0000_1234, 1'b1, 64'h0000_0000_8000_1234},
        '{32'h0040_0010, 1'b1, 64'h0000_0000_8040_0010},
        '{32'h00C3_FFFF, 1'b1, 64'h0000_0012_80C3_FFFF},
        '{32'h0140_0000, 1'b0, 64'h0},
        '{32'h07FF_FFFF, 1'b1, 64'h0000_0000_87FF_FFFF},
        '{32'h0800_0000, 1'b0, 64'h0},
        '{32'hFFFF_FFFF, 1'b0, 64'h0},
        '{32'h0080_0000, 1'b1, 64'h0000_0000_8080_0000}
    };

    task automatic check(input string req, input logic h, input logic [63:0] a,
                         input logic eh, input logic [63:0] ea);
        checks++;
        if (h !== eh || a !== ea) begin
            errors++;
            $display("FAIL %s: hit=%0b addr=%h expected hit=%0b addr=%h", req, h, a, eh, ea);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic look_chk(input string req, input logic [31:0] a, input logic eh, input logic [63:0] ea);
        look(a);
        checks++;
        if (rsp_valid !== 1'b1) begin
            errors++;
            $display("FAIL %s: rsp_valid=%0b expected 1", req, rsp_valid);
        end
        check(req, rsp_hit, rsp_addr, eh, ea);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R9: run hung, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", rsp_hit, rsp_addr, 1'b0, 64'd0);
        checks++;
        if (rsp_valid !== 1'b0) begin errors++; $display("FAIL R1: rsp_valid=%0b expected 0", rsp_valid); end
        rst_n = 1'b1;
        look_chk("R1", 32'h0, 1'b0, 64'd0);

        wr(12'h030, 32'h0000_0002);
        for (int n = 0; n < 32; n++) begin
            wr(12'(12'h200 + 8*n), 32'h8000_0000 + 32'(n) * 32'h0040_0000 + ((n == 5) ? 32'd0 : 32'd1));
            wr(12'(12'h204 + 8*n), (n == 3) ? 32'h12 : 32'h0);
        end
        // R6 global enable still clear
        look_chk("R6", 32'h0000_1234, 1'b0, 64'd0);
        wr(12'h004, 32'h0000_0002);

        for (int i = 0; i < 8; i++) begin
            look_chk("R4/R5/R7/R8 table", VECS[i].a, VECS[i].h, VECS[i].e);
        end

        // R9 hold while idle
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin errors++; $display("FAIL R9: rsp_valid=%0b expected 0", rsp_valid); end
        check("R9 hold", rsp_hit, rsp_addr, 1'b1, 64'h0000_0000_8080_0000);

        // R6 clear bit 1 with all other bits set
        wr(12'h004, 32'hFFFF_FFFD);
        look_chk("R6 disabled", 32'h0000_1234, 1'b0, 64'd0);
        wr(12'h004, 32'h0000_0002);

        // R3 stray writes
        wr(12'h201, 32'h0000_0000);
        wr(12'h300, 32'hDEAD_0001);
        wr(12'h034, 32'h0000_0007);
        wr(12'h1FC, 32'hFFFF_FFFF);
        look_chk("R3 stray", 32'h0040_0010, 1'b1, 64'h0000_0000_8040_0010);
        look_chk("R3 stray", 32'h0000_0010, 1'b1, 64'h0000_0000_8000_0010);

        // R7 disable window 0
        wr(12'h200, 32'h8000_0000);
        look_chk("R7", 32'h0000_0010, 1'b0, 64'd0);
        wr(12'h200, 32'h8000_0001);

        // R2 size write together with a lookup: old size applies
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 12'h030; cfg_wdata = 32'h0000_0000;
        lk_valid = 1'b1; lk_addr = 32'h0010_0005;
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        check("R2 same cycle", rsp_hit, rsp_addr, 1'b1, 64'h0000_0000_8010_0005);
        look_chk("R2 new size", 32'h0010_0005, 1'b1, 64'h0000_0000_8040_0005);
        look_chk("R8 1MiB", 32'h0200_0000, 1'b0, 64'd0);

        // R2 largest size code 7
        wr(12'h030, 32'hFFFF_FFFF);
        look_chk("R2 R5 128MiB", 32'hFFFF_FFFF, 1'b1, 64'h0000_0000_87FF_FFFF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule